// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent translations from virtual page numbers to physical frame numbers for a 32-bit virtual address space with 4 KiB pages. A lookup presents a virtual address and an access kind (read, write or execute). One cycle later the block returns one of three outcomes. A permitted hit returns the physical address. A miss means no valid entry holds the page. A permission fault means the page is present but the access kind is not allowed. The page offset passes through unchanged. Every entry is compared in parallel, and a page may sit in any entry.

On a miss the block only reports the miss. An external page-table walker then resolves the translation, installs it through the fill port with its permission and status bits, and the requester retries. A single invalidate input drops every entry at once. Victims on fill are the lowest-numbered empty entry or, when the buffer is full, the least recently used entry under exact age ordering. Permitted hits mark an entry as referenced, and permitted writes also mark it as modified. Every hit reports the entry's status bits so the walker can see the first reference or modification of a page.

Top module: `tlb_fa`

## Requirements
- R1: On a permitted hit, `res_hit` is 1 in the cycle after the lookup, and `res_paddr` is the entry's frame number in bits 31:12 with the lookup's address bits 11:0 in bits 11:0.
- R2: A lookup whose page number matches no valid entry gives `res_miss`=1 with `res_hit`=0, `res_fault`=0 and `res_paddr`=0.
- R3: Access kind codes are 0 read, 1 write, 2 execute and 3 reserved. A hit is permitted when `fill_perm` bit 0 (read), bit 1 (write) or bit 2 (execute) was set for that kind at fill. Code 3 is never permitted. A hit that is not permitted gives `res_fault`=1, `res_hit`=0 and `res_paddr`=0.
- R4: On any hit, `res_accessed` and `res_dirty` show the entry's status bits as they were before this access. A permitted hit sets the accessed bit. A permitted write sets the dirty bit. A fault changes neither. On a miss both outputs are 0.
- R5: A fill installs page number, frame number, permissions and both status bits as given. A fill of a page number already present overwrites that entry, so no other entry is displaced.
- R6: A fill of a new page takes the lowest-numbered invalid entry. If no entry is invalid, it takes the least recently used entry. Both hits (permitted or not) and fills count as use.
- R7: A fill and a lookup in the same cycle: the fill is performed and the lookup is dropped, so `res_valid` is 0 in the next cycle.
- R8: `inv_all` clears every valid bit and takes priority over fill and lookup in that cycle. Later lookups miss until new fills arrive.
- R9: After reset all entries are invalid and all result outputs are 0.
- R10: `res_valid` is 1 exactly in the cycle after a lookup that was accepted, and in that cycle exactly one of `res_hit`, `res_miss`, `res_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| fill_accessed | input | 1 | Initial accessed bit |
| fill_dirty | input | 1 | Initial dirty bit |
| inv_all | input | 1 | Invalidate every entry |
| res_valid | output | 1 | Result present (one cycle after lookup) |
| res_hit | output | 1 | Permitted hit |
| res_miss | output | 1 | No valid matching entry |
| res_fault | output | 1 | Matching entry forbids this access kind |
| res_paddr | output | 32 | Physical address on a permitted hit, else 0 |
| res_accessed | output | 1 | Entry accessed bit before this access (hits only) |
| res_dirty | output | 1 | Entry dirty bit before this access (hits only) |

## Verification
The assertions assume that reset is held for at least one edge before any request, and that `lk_kind` and the fill fields are driven to known values whenever their strobes are high. The priority rules of R7 and R8 mean the result checks also hold when requests collide, so the random stimulus deliberately overlaps fills, invalidates and lookups. It draws page numbers from a pool of twelve so that hits, misses, refills of resident pages and evictions all occur often. Reserved access code 3 appears only in a directed case.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = 20;
    localparam int PA_W  = PFN_W + OFF_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic [2:0]       perm;     // bit0 read, bit1 write, bit2 execute
        logic             accessed;
        logic             dirty;
    } tlb_entry_t;

    function automatic logic perm_ok(input logic [2:0] perm, input acc_e kind);
        case (kind)
            ACC_READ:  return perm[0];
            ACC_WRITE: return perm[1];
            ACC_EXEC:  return perm[2];
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  tlb_entry_t [N-1:0]  ents,
    input  logic [VPN_W-1:0]    key,
    output logic                found,
    output logic [IDX_W-1:0]    idx
);
    logic [N-1:0] match;

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign match[g] = ents[g].valid && (ents[g].vpn == key);
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign found = |match;
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int N      = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest
);
    logic [IDX_W-1:0] age [N];
    logic [IDX_W-1:0] touched_age;

    assign touched_age = age[touch_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age[i] <= IDX_W'(N - 1 - i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx)   age[i] <= '0;
                else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        oldest = '0;
        for (int i = 0; i < N; i++) begin
            if (age[i] == IDX_W'(N - 1)) oldest = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [31:0]       lk_vaddr,
    input  logic [1:0]        lk_kind,
    input  logic              fill_valid,
    input  logic [19:0]       fill_vpn,
    input  logic [19:0]       fill_pfn,
    input  logic [2:0]        fill_perm,
    input  logic              fill_accessed,
    input  logic              fill_dirty,
    input  logic              inv_all,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_fault,
    output logic [31:0]       res_paddr,
    output logic              res_accessed,
    output logic              res_dirty
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_entry_t [ENTRIES-1:0] ents;

    logic             lk_found, fl_found, any_free, touch, lk_ok;
    logic [IDX_W-1:0] lk_idx, fl_idx, free_idx, lru_idx, fill_idx, touch_idx;
    logic             do_fill, do_look;
    tlb_entry_t       sel;
    acc_e             kind;

    tlb_cam #(.N(ENTRIES)) u_cam_lk (
        .ents(ents), .key(lk_vaddr[VA_W-1:OFF_W]), .found(lk_found), .idx(lk_idx)
    );
    tlb_cam #(.N(ENTRIES)) u_cam_fl (
        .ents(ents), .key(fill_vpn), .found(fl_found), .idx(fl_idx)
    );
    tlb_lru #(.N(ENTRIES)) u_lru (
        .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx), .oldest(lru_idx)
    );

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ents[i].valid) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign do_fill   = fill_valid && !inv_all;
    assign do_look   = lk_valid && !fill_valid && !inv_all;
    assign fill_idx  = fl_found ? fl_idx : (any_free ? free_idx : lru_idx);
    assign kind      = acc_e'(lk_kind);
    assign sel       = ents[lk_idx];
    assign lk_ok     = perm_ok(sel.perm, kind);
    assign touch     = do_fill || (do_look && lk_found);
    assign touch_idx = do_fill ? fill_idx : lk_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ents         <= '0;
            res_valid    <= 1'b0;
            res_hit      <= 1'b0;
            res_miss     <= 1'b0;
            res_fault    <= 1'b0;
            res_paddr    <= '0;
            res_accessed <= 1'b0;
            res_dirty    <= 1'b0;
        end else begin
            res_valid    <= do_look;
            res_hit      <= do_look && lk_found && lk_ok;
            res_miss     <= do_look && !lk_found;
            res_fault    <= do_look && lk_found && !lk_ok;
            res_paddr    <= (do_look && lk_found && lk_ok) ?
                            {sel.pfn, lk_vaddr[OFF_W-1:0]} : '0;
            res_accessed <= do_look && lk_found && sel.accessed;
            res_dirty    <= do_look && lk_found && sel.dirty;

            if (inv_all) begin
                for (int i = 0; i < ENTRIES; i++) ents[i].valid <= 1'b0;
            end else if (do_fill) begin
                ents[fill_idx] <= '{valid: 1'b1, vpn: fill_vpn, pfn: fill_pfn,
                                    perm: fill_perm, accessed: fill_accessed,
                                    dirty: fill_dirty};
            end else if (do_look && lk_found && lk_ok) begin
                ents[lk_idx].accessed <= 1'b1;
                if (kind == ACC_WRITE) ents[lk_idx].dirty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [31:0] lk_vaddr,
    input logic        fill_valid,
    input logic        inv_all,
    input logic        res_valid,
    input logic        res_hit,
    input logic        res_miss,
    input logic        res_fault,
    input logic [31:0] res_paddr
);
    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_paddr[11:0] == $past(lk_vaddr[11:0]));

    assert_no_addr_without_hit_R2: assert property (@(posedge clk) disable iff (rst)
        !res_hit |-> res_paddr == 32'd0);

    assert_fill_drops_lookup_R7: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && fill_valid) |=> !res_valid);

    assert_inv_then_miss_R8: assert property (@(posedge clk) disable iff (rst)
        inv_all ##1 (lk_valid && !fill_valid && !inv_all) |=> res_miss);

    assert_quiet_after_reset_R9: assert property (@(posedge clk)
        $fell(rst) |-> !res_valid && !res_hit && !res_miss && !res_fault);

    assert_result_timing_R10: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !fill_valid && !inv_all) |=> res_valid);

    assert_no_spurious_result_R10: assert property (@(posedge clk) disable iff (rst)
        !(lk_valid && !fill_valid && !inv_all) |=> !res_valid);

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $countones({res_hit, res_miss, res_fault}) == 1);

    assert_outcome_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_hit && !res_miss && !res_fault);
endmodule

bind tlb_fa tlb_fa_chk u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .fill_valid(fill_valid), .inv_all(inv_all), .res_valid(res_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
    .res_paddr(res_paddr)
);

// File: tb/tlb_fa_tb.sv
`timescale 1ns/1ps
module tlb_fa_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, fill_valid = 0, inv_all = 0;
    logic [31:0] lk_vaddr = 0;
    logic [1:0]  lk_kind = 0;
    logic [19:0] fill_vpn = 0, fill_pfn = 0;
    logic [2:0]  fill_perm = 0;
    logic        fill_accessed = 0, fill_dirty = 0;
    logic        res_valid, res_hit, res_miss, res_fault, res_accessed, res_dirty;
    logic [31:0] res_paddr;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tlb_fa #(.ENTRIES(N)) u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_kind(lk_kind), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_accessed(fill_accessed),
        .fill_dirty(fill_dirty), .inv_all(inv_all), .res_valid(res_valid),
        .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
        .res_paddr(res_paddr), .res_accessed(res_accessed), .res_dirty(res_dirty)
    );

    // reference state
    bit         m_v[N];
    logic [19:0] m_vpn[N], m_pfn[N];
    logic [2:0] m_perm[N];
    bit         m_a[N], m_d[N];
    int         m_age[N];

    function automatic bit allowed(logic [2:0] p, logic [1:0] k);
        if (k == 2'd0) return p[0];
        if (k == 2'd1) return p[1];
        if (k == 2'd2) return p[2];
        return 1'b0;
    endfunction

    function automatic int find(logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic void use_entry(int t);
        int old = m_age[t];
        for (int i = 0; i < N; i++) begin
            if (i == t) m_age[i] = 0;
            else if (m_age[i] < old) m_age[i]++;
        end
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_a[i] = 0; m_d[i] = 0; m_age[i] = N - 1 - i;
        end
    endfunction

    task automatic chk(string req, logic [37:0] act, logic [37:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle; called at a negedge
    task automatic step(bit lv, logic [31:0] va, logic [1:0] k, bit fv,
                        logic [19:0] fvpn, logic [19:0] fpfn, logic [2:0] fp,
                        bit fa, bit fd, bit inv, string tag);
        logic [37:0] exp;
        int h;
        lk_valid = lv; lk_vaddr = va; lk_kind = k;
        fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; fill_perm = fp;
        fill_accessed = fa; fill_dirty = fd; inv_all = inv;
        exp = '0;
        if (inv) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (fv) begin
            h = find(fvpn);
            if (h < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) h = i;
                if (h < 0) for (int i = 0; i < N; i++) if (m_age[i] == N - 1) h = i;
            end
            m_v[h] = 1; m_vpn[h] = fvpn; m_pfn[h] = fpfn; m_perm[h] = fp;
            m_a[h] = fa; m_d[h] = fd;
            use_entry(h);
        end else if (lv) begin
            h = find(va[31:12]);
            if (h < 0) exp = {1'b1, 3'b010, 2'b00, 32'd0};
            else begin
                if (allowed(m_perm[h], k))
                    exp = {1'b1, 3'b100, m_a[h], m_d[h], m_pfn[h], va[11:0]};
                else
                    exp = {1'b1, 3'b001, m_a[h], m_d[h], 32'd0};
                if (allowed(m_perm[h], k)) begin
                    m_a[h] = 1;
                    if (k == 2'd1) m_d[h] = 1;
                end
                use_entry(h);
            end
        end
        @(posedge clk); #1;
        chk(tag, {res_valid, res_hit, res_miss, res_fault, res_accessed,
                  res_dirty, res_paddr}, exp);
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; inv_all = 0;
    endtask

    task automatic look(logic [19:0] vpn, logic [11:0] off, logic [1:0] k, string tag);
        step(1, {vpn, off}, k, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic [2:0] p,
                        bit a, bit d, string tag);
        step(0, 0, 0, 1, vpn, pfn, p, a, d, 0, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R9: reset state
        chk("R9 reset outputs", {res_valid, res_hit, res_miss, res_fault,
            res_accessed, res_dirty, res_paddr}, '0);
        look(20'h12345, 12'h0AB, 2'd0, "R9 R2 miss after reset");

        // R1 R3 R4 directed
        fill(20'h00100, 20'hABCDE, 3'b001, 0, 0, "R5 fill read-only");
        look(20'h00100, 12'hFFF, 2'd0, "R1 R4 read hit");
        look(20'h00100, 12'h000, 2'd1, "R3 write fault");
        look(20'h00100, 12'h123, 2'd2, "R3 exec fault");
        look(20'h00100, 12'h123, 2'd3, "R3 reserved kind fault");
        fill(20'h00200, 20'h00042, 3'b011, 0, 0, "R5 fill rw");
        look(20'h00200, 12'h456, 2'd2, "R3 R4 fault keeps status");
        look(20'h00200, 12'h456, 2'd1, "R4 write hit");
        look(20'h00200, 12'h789, 2'd0, "R4 dirty and accessed seen");

        // R5 refill overwrites in place
        fill(20'h00100, 20'h11111, 3'b111, 1, 1, "R5 refill");
        look(20'h00100, 12'h010, 2'd2, "R5 new frame after refill");
        look(20'h00200, 12'h010, 2'd0, "R5 other entry kept");

        // R6 eviction order
        for (int i = 0; i < 6; i++) fill(20'h00300 + 20'(i), 20'h00500 + 20'(i), 3'b111, 0, 0, "R6 fill to full");
        look(20'h00100, 12'h0, 2'd0, "R6 touch oldest");
        fill(20'h00900, 20'h00999, 3'b111, 0, 0, "R6 fill evicts lru");
        look(20'h00200, 12'h0, 2'd0, "R6 lru entry evicted");
        look(20'h00100, 12'h0, 2'd0, "R6 recently used kept");
        look(20'h00900, 12'h0, 2'd0, "R6 new entry present");

        // R7 collision
        step(1, 32'h00100000, 0, 1, 20'h00A00, 20'h00A0A, 3'b111, 0, 0, 0, "R7 fill beats lookup");
        look(20'h00A00, 12'h5, 2'd0, "R7 fill done");

        // R8 invalidate beats fill
        step(1, 32'h00100000, 0, 1, 20'h00B00, 20'h00B0B, 3'b111, 0, 0, 1, "R8 inv cycle");
        look(20'h00100, 12'h0, 2'd0, "R8 miss after inv");
        look(20'h00B00, 12'h0, 2'd0, "R8 fill dropped by inv");

        // random mix
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            logic [19:0] vpn = 20'hA0000 + 20'($urandom_range(0, 11) * 3);
            logic [31:0] va = {vpn, 12'($urandom)};
            logic [1:0] k = 2'($urandom_range(0, 2));
            if (r < 2)
                step($urandom_range(0, 1), va, k, $urandom_range(0, 1), vpn,
                     20'($urandom), 3'($urandom), 0, 0, 1, "R8 random inv");
            else if (r < 25)
                step($urandom_range(0, 1), va, k, 1, vpn, 20'($urandom), 3'($urandom),
                     1'($urandom), 1'($urandom), 0, "R5 R6 R7 random fill");
            else
                step(1, va, k, 0, 0, 0, 0, 0, 0, 0, "R1 R2 R3 R4 R10 random lookup");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule